// File: doc/BRIEF.md
# Miss Tracking Pool with Prefetch Headroom

This block keeps the set of outstanding cache misses for a cache controller. Each entry holds the line address of one miss and a state: free, waiting to be sent to memory, or in service at memory. Demand misses and hardware prefetches both allocate entries. Entries are freed when their fill completes. A combinational address probe reports which entry, if any, already tracks a given address. Two separate occupancy limits decide admission. Demand misses see a general limit. Prefetches see a tighter limit, so a fixed number of entries stays free for demand traffic and a busy prefetcher cannot starve the core.

The physical pool has `NUM_CFG + GEN_RSV - 1` entries. Demand misses are refused once the allocated count exceeds the pool size minus `GEN_RSV`. A prefetch is admitted only when the count is strictly below the pool size minus `GEN_RSV + DMD_RSV`, and only in a cycle where no demand miss and no pending write are presented. Every allocation takes the lowest free entry, and the entry index is returned in the same cycle as the grant. With the defaults (8 configured, general reserve 4, demand reserve 1), the pool has 11 entries, demand is refused at 8 or more, and prefetch is refused at 6 or more.

Top module: `mshr_pool`

## Requirements
- R1: After reset the allocated count and the in-service count are 0, `full_o` is 0, `can_pf_o` is 1, `err_o` is 0 and the probe reports no hit.
- R2: A demand request is granted in the same cycle when the allocated count is at most pool size minus `GEN_RSV` (7 by default). `full_o` is 1 exactly when the count is above that value. A granted request receives the lowest-indexed free entry on `dmd_idx_o`, and the count rises by one on the next clock edge.
- R3: `can_pf_o` is 1 exactly when the allocated count is below pool size minus `GEN_RSV` minus `DMD_RSV` (6 by default). A prefetch is never granted when `can_pf_o` is 0. A granted prefetch gets the lowest free entry on `pf_idx_o`.
- R4: A prefetch request is not granted in any cycle in which `dmd_req_i` or `wr_pend_i` is 1.
- R5: The probe returns `lookup_hit_o`=1 and the lowest index among valid entries whose address equals `lookup_addr_i`. It returns `lookup_hit_o`=0 when no valid entry matches. A freed entry no longer matches.
- R6: A deallocation of a valid entry frees it, and the count falls by one on the next clock edge. An allocation and a deallocation in the same cycle leave the count unchanged.
- R7: `err_o` is 1 in the same cycle when a deallocation names a free or out-of-range index, or when a demand request meets `full_o`=1. The offending operation changes no state.
- R8: An issue strobe moves a waiting entry to in service and raises the in-service count by one. Issuing a free entry or an entry already in service is ignored.
- R9: Deallocating an entry that is in service lowers the in-service count by one. Deallocating a waiting entry leaves the in-service count unchanged. If an entry is issued and another is deallocated in the same cycle, the in-service count changes by the sum of the two effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dmd_req_i | input | 1 | Demand miss allocation request |
| dmd_addr_i | input | ADDR_W | Demand miss line address |
| dmd_gnt_o | output | 1 | Demand request granted this cycle |
| dmd_idx_o | output | IDX_W | Entry given to the demand request |
| wr_pend_i | input | 1 | A write is selected this cycle; blocks prefetch |
| pf_req_i | input | 1 | Prefetch allocation request |
| pf_addr_i | input | ADDR_W | Prefetch line address |
| pf_gnt_o | output | 1 | Prefetch granted this cycle |
| pf_idx_o | output | IDX_W | Entry given to the prefetch |
| issue_i | input | 1 | Mark an entry as sent to memory |
| issue_idx_i | input | IDX_W | Entry to mark |
| dealloc_i | input | 1 | Free an entry |
| dealloc_idx_i | input | IDX_W | Entry to free |
| lookup_addr_i | input | ADDR_W | Address to probe |
| lookup_hit_o | output | 1 | A valid entry matches the probe |
| lookup_idx_o | output | IDX_W | Lowest matching entry |
| full_o | output | 1 | Pool refuses demand requests |
| can_pf_o | output | 1 | Pool would accept a prefetch |
| alloc_cnt_o | output | CNT_W | Allocated entries |
| insvc_cnt_o | output | CNT_W | Entries in service |
| err_o | output | 1 | Illegal deallocation or demand request while full |

## Verification
Allocation and deallocation can land in the same cycle. The bench provokes this by presenting a demand request together with a deallocation of a valid entry. It expects the grant to take the lowest entry that was free before the edge, not the one being freed, and it expects the count to stay unchanged. Issue and deallocation also collide: one entry is issued while an in-service entry is freed. The in-service count must come out unchanged, and the state of each entry is confirmed afterwards through later frees and count readings.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    ENT_FREE = 2'd0,
    ENT_WAIT = 2'd1,
    ENT_SVC  = 2'd2
  } ent_st_e;
endpackage

// File: rtl/mshr_pick.sv
// lowest-index set bit finder
module mshr_pick #(
  parameter int N     = 11,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mshr_entry_arr.sv
module mshr_entry_arr
  import mshr_pkg::*;
#(
  parameter int N      = 11,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [IDX_W-1:0]  alloc_idx_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic              issue_i,
  input  logic [IDX_W-1:0]  issue_idx_i,
  input  logic              dealloc_i,
  input  logic [IDX_W-1:0]  dealloc_idx_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  output logic [N-1:0]      valid_o,
  output logic [N-1:0]      issued_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_ent
    ent_st_e           st_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q   <= ENT_FREE;
        addr_q <= '0;
      end else if (dealloc_i && dealloc_idx_i == IDX_W'(g)) begin
        st_q <= ENT_FREE;
      end else if (alloc_i && alloc_idx_i == IDX_W'(g)) begin
        st_q   <= ENT_WAIT;
        addr_q <= alloc_addr_i;
      end else if (issue_i && issue_idx_i == IDX_W'(g) && st_q == ENT_WAIT) begin
        st_q <= ENT_SVC;
      end
    end

    assign valid_o[g]  = (st_q != ENT_FREE);
    assign issued_o[g] = (st_q == ENT_SVC);
    assign match[g]    = (st_q != ENT_FREE) && (addr_q == lookup_addr_i);
  end

  mshr_pick #(.N(N), .IDX_W(IDX_W)) u_hit_pick (
    .req_i (match),
    .any_o (hit_o),
    .idx_o (hit_idx_o)
  );
endmodule

// File: rtl/mshr_occ.sv
// occupancy counters and admission thresholds
module mshr_occ #(
  parameter int N       = 11,
  parameter int CNT_W   = 4,
  parameter int GEN_RSV = 4,
  parameter int DMD_RSV = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             svc_inc_i,
  input  logic             svc_dec_i,
  output logic [CNT_W-1:0] alloc_cnt_o,
  output logic [CNT_W-1:0] insvc_cnt_o,
  output logic             full_o,
  output logic             can_pf_o
);
  localparam logic [CNT_W-1:0] FULL_LIM = CNT_W'(N - GEN_RSV);
  localparam logic [CNT_W-1:0] PF_LIM   = CNT_W'(N - GEN_RSV - DMD_RSV);

  logic [CNT_W-1:0] cnt_q, svc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      case ({inc_i, dec_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      svc_q <= '0;
    end else begin
      case ({svc_inc_i, svc_dec_i})
        2'b10:   svc_q <= svc_q + 1'b1;
        2'b01:   svc_q <= svc_q - 1'b1;
        default: svc_q <= svc_q;
      endcase
    end
  end

  assign alloc_cnt_o = cnt_q;
  assign insvc_cnt_o = svc_q;
  assign full_o      = (cnt_q > FULL_LIM);
  assign can_pf_o    = (cnt_q < PF_LIM);
endmodule

// File: rtl/mshr_pool.sv
module mshr_pool #(
  parameter int NUM_CFG = 8,
  parameter int GEN_RSV = 4,
  parameter int DMD_RSV = 1,
  parameter int ADDR_W  = 32,
  localparam int N      = NUM_CFG + GEN_RSV - 1,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1,
  localparam int CNT_W  = $clog2(N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dmd_req_i,
  input  logic [ADDR_W-1:0] dmd_addr_i,
  output logic              dmd_gnt_o,
  output logic [IDX_W-1:0]  dmd_idx_o,
  input  logic              wr_pend_i,
  input  logic              pf_req_i,
  input  logic [ADDR_W-1:0] pf_addr_i,
  output logic              pf_gnt_o,
  output logic [IDX_W-1:0]  pf_idx_o,
  input  logic              issue_i,
  input  logic [IDX_W-1:0]  issue_idx_i,
  input  logic              dealloc_i,
  input  logic [IDX_W-1:0]  dealloc_idx_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  output logic              lookup_hit_o,
  output logic [IDX_W-1:0]  lookup_idx_o,
  output logic              full_o,
  output logic              can_pf_o,
  output logic [CNT_W-1:0]  alloc_cnt_o,
  output logic [CNT_W-1:0]  insvc_cnt_o,
  output logic              err_o
);
  localparam int NP     = 1 << IDX_W;
  localparam int PF_LIM = N - GEN_RSV - DMD_RSV;

  if (GEN_RSV + DMD_RSV >= N) begin : g_bad_cfg
    $error("mshr_pool: reserves must be smaller than the pool");
  end

  logic [N-1:0]     valid, issued;
  logic [NP-1:0]    valid_pad, issued_pad;
  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic             alloc, dealloc_ok, issue_ok, svc_dec;
  logic [ADDR_W-1:0] alloc_addr;

  mshr_pick #(.N(N), .IDX_W(IDX_W)) u_free_pick (
    .req_i (~valid),
    .any_o (free_any),
    .idx_o (free_idx)
  );

  assign valid_pad  = NP'(valid);
  assign issued_pad = NP'(issued);

  // demand and write traffic take precedence over prefetch
  assign dmd_gnt_o  = dmd_req_i && !full_o && free_any;
  assign pf_gnt_o   = pf_req_i && !dmd_req_i && !wr_pend_i && can_pf_o && free_any;
  assign dmd_idx_o  = free_idx;
  assign pf_idx_o   = free_idx;
  assign alloc      = dmd_gnt_o || pf_gnt_o;
  assign alloc_addr = dmd_gnt_o ? dmd_addr_i : pf_addr_i;

  assign dealloc_ok = dealloc_i && valid_pad[dealloc_idx_i];
  assign issue_ok   = issue_i && valid_pad[issue_idx_i] && !issued_pad[issue_idx_i] &&
                      !(dealloc_ok && dealloc_idx_i == issue_idx_i);
  assign svc_dec    = dealloc_ok && issued_pad[dealloc_idx_i];
  assign err_o      = (dealloc_i && !dealloc_ok) || (dmd_req_i && full_o);

  mshr_entry_arr #(.N(N), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_arr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .alloc_i       (alloc),
    .alloc_idx_i   (free_idx),
    .alloc_addr_i  (alloc_addr),
    .issue_i       (issue_ok),
    .issue_idx_i   (issue_idx_i),
    .dealloc_i     (dealloc_ok),
    .dealloc_idx_i (dealloc_idx_i),
    .lookup_addr_i (lookup_addr_i),
    .valid_o       (valid),
    .issued_o      (issued),
    .hit_o         (lookup_hit_o),
    .hit_idx_o     (lookup_idx_o)
  );

  mshr_occ #(.N(N), .CNT_W(CNT_W), .GEN_RSV(GEN_RSV), .DMD_RSV(DMD_RSV)) u_occ (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .inc_i       (alloc),
    .dec_i       (dealloc_ok),
    .svc_inc_i   (issue_ok),
    .svc_dec_i   (svc_dec),
    .alloc_cnt_o (alloc_cnt_o),
    .insvc_cnt_o (insvc_cnt_o),
    .full_o      (full_o),
    .can_pf_o    (can_pf_o)
  );
endmodule

// File: rtl/mshr_pool_chk.sv
module mshr_pool_chk #(
  parameter int CNT_W  = 4,
  parameter int PF_LIM = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dmd_req_i,
  input logic             wr_pend_i,
  input logic             dealloc_i,
  input logic             dmd_gnt_o,
  input logic             pf_gnt_o,
  input logic             full_o,
  input logic             err_o,
  input logic [CNT_W-1:0] alloc_cnt_o,
  input logic [CNT_W-1:0] insvc_cnt_o
);
  // R2
  full_blocks_dmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !dmd_gnt_o);

  // R2
  dmd_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmd_gnt_o && !dealloc_i) |=> alloc_cnt_o == $past(alloc_cnt_o) + 1'b1);

  // R3
  pf_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_gnt_o |-> alloc_cnt_o < CNT_W'(PF_LIM));

  // R4
  pf_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_gnt_o |-> (!dmd_req_i && !wr_pend_i));

  // R6
  net_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmd_gnt_o && dealloc_i && !err_o) |=> $stable(alloc_cnt_o));

  // R7
  err_no_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !dmd_gnt_o && !pf_gnt_o) |=> $stable(alloc_cnt_o));

  // R8
  svc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insvc_cnt_o <= alloc_cnt_o);

  // R2
  single_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dmd_gnt_o, pf_gnt_o}));
endmodule

bind mshr_pool mshr_pool_chk #(.CNT_W(CNT_W), .PF_LIM(PF_LIM)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dmd_req_i   (dmd_req_i),
  .wr_pend_i   (wr_pend_i),
  .dealloc_i   (dealloc_i),
  .dmd_gnt_o   (dmd_gnt_o),
  .pf_gnt_o    (pf_gnt_o),
  .full_o      (full_o),
  .err_o       (err_o),
  .alloc_cnt_o (alloc_cnt_o),
  .insvc_cnt_o (insvc_cnt_o)
);

// File: tb/sim_mshr_pool.sv
`timescale 1ns/1ps
module sim_mshr_pool;
  localparam int AW = 32;
  localparam int IW = 4;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dmd_req = 1'b0, wr_pend = 1'b0, pf_req = 1'b0;
  logic          issue = 1'b0, dealloc = 1'b0;
  logic [AW-1:0] dmd_addr = '0, pf_addr = '0, lk_addr = '0;
  logic [IW-1:0] issue_idx = '0, dealloc_idx = '0;
  logic          dmd_gnt, pf_gnt, lk_hit, full, can_pf, err;
  logic [IW-1:0] dmd_idx, pf_idx, lk_idx;
  logic [CW-1:0] acnt, scnt;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  mshr_pool u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .dmd_req_i(dmd_req), .dmd_addr_i(dmd_addr), .dmd_gnt_o(dmd_gnt), .dmd_idx_o(dmd_idx),
    .wr_pend_i(wr_pend),
    .pf_req_i(pf_req), .pf_addr_i(pf_addr), .pf_gnt_o(pf_gnt), .pf_idx_o(pf_idx),
    .issue_i(issue), .issue_idx_i(issue_idx),
    .dealloc_i(dealloc), .dealloc_idx_i(dealloc_idx),
    .lookup_addr_i(lk_addr), .lookup_hit_o(lk_hit), .lookup_idx_o(lk_idx),
    .full_o(full), .can_pf_o(can_pf), .alloc_cnt_o(acnt), .insvc_cnt_o(scnt),
    .err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    dmd_req = 0; pf_req = 0; wr_pend = 0; issue = 0; dealloc = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 0;
    #3;
    rst_n = 1;
    @(negedge clk);
  endtask

  // demand allocate, expecting a grant at entry exp_idx
  task automatic dmd_alloc(input logic [AW-1:0] a, input int exp_idx, input string req);
    dmd_req = 1; dmd_addr = a;
    #1;
    chk(req, dmd_gnt, 1);
    chk(req, dmd_idx, exp_idx);
    cyc();
    dmd_req = 0;
  endtask

  task automatic free_ent(input int idx);
    dealloc = 1; dealloc_idx = IW'(idx);
    cyc();
    dealloc = 0;
  endtask

  task automatic t_reset();
    do_reset();
    lk_addr = 32'h55;
    #1;
    chk("R1 alloc count", acnt, 0);
    chk("R1 service count", scnt, 0);
    chk("R1 full", full, 0);
    chk("R1 can_pf", can_pf, 1);
    chk("R1 err", err, 0);
    chk("R1 probe hit", lk_hit, 0);
  endtask

  task automatic t_window();
    do_reset();
    for (int i = 0; i < 3; i++) dmd_alloc(32'h100 + i, i, "R2 demand grant");
    // demand and prefetch together: demand wins
    dmd_req = 1; dmd_addr = 32'h150; pf_req = 1; pf_addr = 32'h200;
    #1;
    chk("R4 pf blocked by demand", pf_gnt, 0);
    chk("R2 demand idx", dmd_idx, 3);
    cyc();
    dmd_req = 0; wr_pend = 1;
    #1;
    chk("R4 pf blocked by write", pf_gnt, 0);
    cyc();
    wr_pend = 0;
    chk("R4 no alloc while blocked", acnt, 4);
    for (int i = 4; i < 6; i++) begin
      #1;
      chk("R3 pf grant", pf_gnt, 1);
      chk("R3 pf idx", pf_idx, i);
      cyc();
    end
    #1;
    chk("R3 can_pf at limit", can_pf, 0);
    chk("R3 pf refused at limit", pf_gnt, 0);
    cyc();
    pf_req = 0;
    chk("R3 count at limit", acnt, 6);
    dmd_alloc(32'h160, 6, "R2 demand in headroom");
    #1;
    chk("R2 not full at 7", full, 0);
    dmd_alloc(32'h161, 7, "R2 demand last");
    dmd_req = 1; dmd_addr = 32'h162;
    #1;
    chk("R2 full at 8", full, 1);
    chk("R2 refused when full", dmd_gnt, 0);
    chk("R7 err on full demand", err, 1);
    cyc();
    dmd_req = 0;
    chk("R7 count unchanged", acnt, 8);
  endtask

  task automatic t_dealloc();
    do_reset();
    for (int i = 0; i < 4; i++) dmd_alloc(32'h300 + i, i, "R2 demand grant");
    dealloc = 1; dealloc_idx = 1;
    #1;
    chk("R6 legal free no err", err, 0);
    cyc();
    dealloc = 0;
    lk_addr = 32'h301;
    #1;
    chk("R6 count after free", acnt, 3);
    chk("R5 freed entry not matched", lk_hit, 0);
    dealloc = 1; dealloc_idx = 1;
    #1;
    chk("R7 free of free entry", err, 1);
    cyc();
    dealloc_idx = 15;
    #1;
    chk("R7 out of range free", err, 1);
    cyc();
    dealloc = 0;
    chk("R7 count unchanged", acnt, 3);
    // allocate and free in one cycle
    dmd_req = 1; dmd_addr = 32'h400; dealloc = 1; dealloc_idx = 3;
    #1;
    chk("R6 collide grant", dmd_gnt, 1);
    chk("R6 collide idx", dmd_idx, 1);
    cyc();
    idle();
    lk_addr = 32'h400;
    #1;
    chk("R6 net zero count", acnt, 3);
    chk("R6 new entry hit", lk_hit, 1);
    chk("R6 new entry idx", lk_idx, 1);
    lk_addr = 32'h303;
    #1;
    chk("R6 freed entry gone", lk_hit, 0);
  endtask

  task automatic t_lookup();
    do_reset();
    dmd_alloc(32'h500, 0, "R2 demand grant");
    dmd_alloc(32'h600, 1, "R2 demand grant");
    dmd_alloc(32'h500, 2, "R2 demand grant");
    lk_addr = 32'h500;
    #1;
    chk("R5 dup hit", lk_hit, 1);
    chk("R5 lowest match", lk_idx, 0);
    lk_addr = 32'h600;
    #1;
    chk("R5 single match", lk_idx, 1);
    lk_addr = 32'h700;
    #1;
    chk("R5 miss", lk_hit, 0);
    free_ent(0);
    lk_addr = 32'h500;
    #1;
    chk("R5 next match after free", lk_idx, 2);
  endtask

  task automatic t_issue();
    do_reset();
    for (int i = 0; i < 3; i++) dmd_alloc(32'h800 + i, i, "R2 demand grant");
    issue = 1; issue_idx = 1;
    cyc();
    chk("R8 issue counts", scnt, 1);
    cyc();
    chk("R8 reissue ignored", scnt, 1);
    issue_idx = 5;
    cyc();
    issue = 0;
    chk("R8 free issue ignored", scnt, 1);
    issue = 1; issue_idx = 0; dealloc = 1; dealloc_idx = 1;
    cyc();
    idle();
    chk("R9 issue plus free", scnt, 1);
    chk("R6 count after free", acnt, 2);
    free_ent(2);
    chk("R9 waiting free no change", scnt, 1);
    free_ent(0);
    chk("R9 service free", scnt, 0);
    chk("R6 empty", acnt, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_window();
    t_dealloc();
    t_lookup();
    t_issue();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule